// File: doc/BRIEF.md
# Dual-Vector Single-to-Half Precision Narrowing Packer

This block narrows two wide vectors of 32-bit floating-point values into a single vector of 16-bit values with the same total width. Every element of both sources is converted, with no masking. The results of the first source fill the low half of the output vector in element order. The results of the second source fill the high half in the same order. The vector width is a build-time parameter; it must be a multiple of 32.

Each lane performs a complete IEEE 754 narrowing conversion. The caller selects one of four rounding directions for each operation. The caller also supplies two mode bits: one forces every NaN result to a single canonical value, and the other flushes results that are too small to be normal to zero. The exception flags raised by all lanes are OR-combined into one four-bit word that travels with the packed result.

Operations enter through a valid/ready handshake. A single output register presents the result one cycle after acceptance. The output register holds its contents while the consumer stalls.

Top module: `vec_narrow_pack`

## Requirements
- R1: With E = VL/32, the conversion of 32-bit element e of `src_a` (bits 32e+31..32e) appears in 16-bit output lane e, and the conversion of element e of `src_b` appears in output lane E+e; every one of the 2E output lanes is rewritten by every accepted operation.
- R2: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. An operation accepted on a rising edge (with `in_valid` and `in_ready` both high) is presented on `out_valid`/`out_data`/`out_flags` after that edge. While `out_valid` is high and `out_ready` is low, the outputs hold. After reset, `out_valid` is low.
- R3: A finite input that is exactly representable as a normal half-precision value converts to that value, and no flag is raised (for example 1.0 gives 0x3C00 and 65504 gives 0x7BFF).
- R4: `rmode` selects the rounding direction: 0 is nearest-even, 1 is toward +infinity, 2 is toward -infinity, and 3 is toward zero. Any discarded nonzero bits raise the inexact flag.
- R5: If the correctly rounded magnitude exceeds 65504, the overflow and inexact flags are raised. The result is infinity under nearest-even, and under a directed mode whose direction points away from zero for that sign. Otherwise the result is the largest finite value 0x7BFF with the input's sign.
- R6: When `fz_en` is low, a result whose magnitude before rounding is below 2^-14 is rounded to a subnormal, or to zero or the smallest normal. Underflow is raised only if the result is also inexact. An exact subnormal such as 2^-24 gives 0x0001 with no flag.
- R7: When `fz_en` is high, a nonzero input whose magnitude is below 2^-14 and whose exponent field is nonzero gives a zero with the input's sign, and raises only the underflow flag. A 32-bit denormal input gives a signed zero with no flag.
- R8: When `dn_en` is low, a NaN input gives a NaN that keeps its sign, has its quiet bit (bit 9) set, and carries input mantissa bits 21..13 in output bits 8..0. A signalling NaN, which has input bit 22 clear, raises the invalid flag.
- R9: When `dn_en` is high, every NaN input gives 0x7E00. The invalid flag still follows the rule in R8.
- R10: Infinities and zeros pass through with their sign (0x7C00, 0xFC00, 0x0000, 0x8000), and no flag is raised.
- R11: `out_flags` is the bitwise OR of the flags of all lanes. Bit 0 is inexact, bit 1 is underflow, bit 2 is overflow, and bit 3 is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| src_a | input | VL | First source vector of 32-bit elements |
| src_b | input | VL | Second source vector of 32-bit elements |
| rmode | input | 2 | Rounding direction code |
| dn_en | input | 1 | Canonical NaN output enable |
| fz_en | input | 1 | Flush tiny results to zero |
| out_ready | input | 1 | Consumer takes the presented result |
| out_valid | output | 1 | Result register holds a result |
| out_data | output | VL | Packed 16-bit results |
| out_flags | output | 4 | OR of lane exception flags |

## Verification
On every cycle, the assertions check the handshake. An accepted operation must appear on the next cycle, a stalled result must not move, and `in_ready` must be high when the register is empty. They also check two consistency rules between flags and data: overflow never appears without inexact, and invalid only appears alongside a quiet NaN lane. Only the bench's scenarios can show the numeric content. This covers lane placement and the bit-exact values under each rounding direction, the choice between saturation and infinity, subnormal rounding, flush behaviour, NaN payload handling and the canonical NaN, and the OR-merging of mixed flags.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

  localparam int SP_W = 32;
  localparam int HP_W = 16;

  // Rounding direction codes
  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_UP      = 2'd1,
    RM_DOWN    = 2'd2,
    RM_ZERO    = 2'd3
  } rmode_e;

  // Bit 3 invalid, bit 2 overflow, bit 1 underflow, bit 0 inexact
  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } fflags_t;

endpackage

// File: rtl/fpn_round_dec.sv
module fpn_round_dec
  import fpn_pkg::*;
(
  input  rmode_e rmode,
  input  logic   sgn,
  input  logic   lsb,
  input  logic   grd,
  input  logic   rnd,
  input  logic   stk,
  output logic   inc
);

  logic lost;

  always_comb begin
    lost = grd | rnd | stk;
    unique case (rmode)
      RM_NEAREST: inc = grd & (rnd | stk | lsb);
      RM_UP:      inc = ~sgn & lost;
      RM_DOWN:    inc = sgn & lost;
      default:    inc = 1'b0;
    endcase
  end

endmodule

// File: rtl/fpn_lane.sv
module fpn_lane
  import fpn_pkg::*;
(
  input  logic [SP_W-1:0] sp_in,
  input  rmode_e          rmode,
  input  logic            dn_en,
  input  logic            fz_en,
  output logic [HP_W-1:0] hp_out,
  output fflags_t         flags
);

  localparam logic [7:0] MIN_NORM_EX = 8'd113; // biased 32-bit exponent of 2^-14
  localparam logic [7:0] OVF_EX      = 8'd143; // biased 32-bit exponent of 2^16
  localparam logic [3:0] MAX_SUB_SH  = 4'd13;

  logic        sgn;
  logic [7:0]  ex;
  logic [22:0] man;
  logic        is_nan, is_inf, is_den_in, is_sub, is_big, tiny;
  logic [23:0] sig;
  logic [7:0]  eff_ex, diff;
  logic [3:0]  sub_sh;
  logic [36:0] ext;
  logic [4:0]  hexp;
  logic        grd, rnd, stk, lost, inc;
  logic [14:0] base, rounded;
  logic        sat;

  // Field split and alignment ahead of rounding
  always_comb begin
    sgn       = sp_in[31];
    ex        = sp_in[30:23];
    man       = sp_in[22:0];
    is_nan    = (ex == 8'hFF) && (man != '0);
    is_inf    = (ex == 8'hFF) && (man == '0);
    is_den_in = (ex == 8'h00) && (man != '0);
    is_sub    = ex < MIN_NORM_EX;
    is_big    = (ex >= OVF_EX) && (ex != 8'hFF);
    sig       = {ex != 8'h00, man};
    tiny      = is_sub && (sig != '0);
    eff_ex    = (ex == 8'h00) ? 8'd1 : ex;
    diff      = MIN_NORM_EX - eff_ex;
    sub_sh    = !is_sub ? 4'd0 : ((diff > 8'(MAX_SUB_SH)) ? MAX_SUB_SH : diff[3:0]);
    ext       = {sig, 13'b0} >> sub_sh;
    hexp      = ex[4:0] + 5'd16;
    grd       = ext[25];
    rnd       = ext[24];
    stk       = |ext[23:0];
    lost      = grd | rnd | stk;
    base      = is_sub ? {4'b0, ext[36:26]} : {hexp, ext[35:26]};
  end

  fpn_round_dec u_round (
    .rmode (rmode),
    .sgn   (sgn),
    .lsb   (ext[26]),
    .grd   (grd),
    .rnd   (rnd),
    .stk   (stk),
    .inc   (inc)
  );

  // Final selection by class, in priority order
  always_comb begin
    rounded = base + {14'b0, inc};
    sat     = (rmode == RM_ZERO) || (rmode == RM_UP && sgn) || (rmode == RM_DOWN && !sgn);
    flags   = '0;
    if (is_nan) begin
      hp_out        = dn_en ? 16'h7E00 : {sgn, 5'h1F, 1'b1, man[21:13]};
      flags.invalid = ~man[22];
    end else if (is_inf) begin
      hp_out = {sgn, 15'h7C00};
    end else if (fz_en && is_den_in) begin
      hp_out = {sgn, 15'h0000};
    end else if (fz_en && tiny) begin
      hp_out          = {sgn, 15'h0000};
      flags.underflow = 1'b1;
    end else if (is_big || (rounded[14:10] == 5'h1F)) begin
      hp_out         = {sgn, sat ? 15'h7BFF : 15'h7C00};
      flags.overflow = 1'b1;
      flags.inexact  = 1'b1;
    end else begin
      hp_out          = {sgn, rounded};
      flags.inexact   = lost;
      flags.underflow = tiny & lost;
    end
  end

endmodule

// File: rtl/vec_narrow_pack.sv
module vec_narrow_pack
  import fpn_pkg::*;
#(
  parameter int VL = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [VL-1:0] src_a,
  input  logic [VL-1:0] src_b,
  input  logic [1:0]    rmode,
  input  logic          dn_en,
  input  logic          fz_en,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [VL-1:0] out_data,
  output logic [3:0]    out_flags
);

  localparam int ELEMS = VL / SP_W;
  localparam int LANES = 2 * ELEMS;

  logic [VL-1:0] data_nxt;
  fflags_t       lane_flags [LANES];
  fflags_t       flags_nxt;
  logic          load, valid_nxt;
  logic          any_qnan;

  // Lanes: first source feeds the low half, second source the high half
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SP_W-1:0] lane_in;
    if (i < ELEMS) begin : g_lo
      assign lane_in = src_a[i*SP_W +: SP_W];
    end else begin : g_hi
      assign lane_in = src_b[(i-ELEMS)*SP_W +: SP_W];
    end
    fpn_lane u_lane (
      .sp_in  (lane_in),
      .rmode  (rmode_e'(rmode)),
      .dn_en  (dn_en),
      .fz_en  (fz_en),
      .hp_out (data_nxt[i*HP_W +: HP_W]),
      .flags  (lane_flags[i])
    );
  end

  always_comb begin
    flags_nxt = '0;
    for (int i = 0; i < LANES; i++) begin
      flags_nxt = flags_nxt | lane_flags[i];
    end
  end

  // Handshake next state
  always_comb begin
    in_ready  = ~out_valid | out_ready;
    load      = in_valid & in_ready;
    valid_nxt = load | (out_valid & ~out_ready);
  end

  // Reset is asserted asynchronously, released by the upstream synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_flags <= '0;
    end else begin
      out_valid <= valid_nxt;
      if (load) begin
        out_data  <= data_nxt;
        out_flags <= flags_nxt;
      end
    end
  end

  always_comb begin
    any_qnan = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      any_qnan = any_qnan | ((out_data[i*HP_W+10 +: 5] == 5'h1F) & out_data[i*HP_W+9]);
    end
  end

  a_r2_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_flags)));

  a_r2_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r5_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[2]) |-> out_flags[0]);

  a_r8_invalid_qnan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[3]) |-> any_qnan);

endmodule

// File: tb/vec_narrow_pack_tb_top.sv
module vec_narrow_pack_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int VL = 128;

  logic          clk, rst_n;
  logic          in_valid, in_ready;
  logic [VL-1:0] src_a, src_b;
  logic [1:0]    rmode;
  logic          dn_en, fz_en;
  logic          out_ready, out_valid;
  logic [VL-1:0] out_data;
  logic [3:0]    out_flags;

  int n_chk = 0;
  int n_bad = 0;

  logic [VL-1:0] exp_d_q [$];
  logic [3:0]    exp_f_q [$];
  string         tag_q   [$];

  vec_narrow_pack #(.VL(VL)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_a(src_a), .src_b(src_b), .rmode(rmode), .dn_en(dn_en), .fz_en(fz_en),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .out_flags(out_flags)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [127:0] pk32(input logic [31:0] e0, e1, e2, e3);
    return {e3, e2, e1, e0};
  endfunction

  function automatic logic [127:0] pk16(input logic [15:0] h0, h1, h2, h3, h4, h5, h6, h7);
    return {h7, h6, h5, h4, h3, h2, h1, h0};
  endfunction

  task automatic check(input bit ok, input string what, input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", what, act, expv);
    end
  endtask

  // Driver: offer one operation, push its expectation when taken
  task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic [1:0] rm,
                        input logic dn, input logic fz, input logic [127:0] ed,
                        input logic [3:0] ef, input string tag);
    src_a = a; src_b = b; rmode = rm; dn_en = dn; fz_en = fz; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    exp_d_q.push_back(ed);
    exp_f_q.push_back(ef);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor: compare every transferred result against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_d_q.size() == 0) begin
        check(1'b0, "R2 output with no pending operation", {124'b0, out_flags}, '0);
      end else begin
        logic [127:0] ed;
        logic [3:0]   ef;
        string        tg;
        ed = exp_d_q.pop_front();
        ef = exp_f_q.pop_front();
        tg = tag_q.pop_front();
        check(out_data == ed, {tg, " data"}, out_data, ed);
        check(out_flags == ef, {tg, " flags R11"}, {124'b0, out_flags}, {124'b0, ef});
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  localparam logic [31:0] ONE = 32'h3F800000;
  localparam logic [15:0] H1  = 16'h3C00;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; src_a = '0; src_b = '0;
    rmode = 2'd0; dn_en = 1'b0; fz_en = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R2 reset out_valid", {127'b0, out_valid}, '0);
    check(in_ready == 1'b1, "R2 reset in_ready", {127'b0, in_ready}, 128'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3: exact values, placement of both halves
    run_op(pk32(ONE, 32'h40000000, 32'hBFC00000, 32'h3F000000),
           pk32(32'h477FE000, 32'h38800000, 32'h40400000, 32'hC0800000), 2'd0, 0, 0,
           pk16(H1, 16'h4000, 16'hBE00, 16'h3800, 16'h7BFF, 16'h0400, 16'h4200, 16'hC400),
           4'b0000, "R1 R3 exact");
    run_op(pk32(32'h477FE000, 32'h38800000, 32'h40400000, 32'hC0800000),
           pk32(ONE, 32'h40000000, 32'hBFC00000, 32'h3F000000), 2'd0, 0, 0,
           pk16(16'h7BFF, 16'h0400, 16'h4200, 16'hC400, H1, 16'h4000, 16'hBE00, 16'h3800),
           4'b0000, "R1 swapped halves");

    // R4: the four rounding directions
    run_op(pk32(32'h3F801000, 32'hBF801000, 32'h3F803000, 32'h3F801001), pk32(ONE, ONE, ONE, ONE),
           2'd0, 0, 0, pk16(16'h3C00, 16'hBC00, 16'h3C02, 16'h3C01, H1, H1, H1, H1), 4'b0001, "R4 nearest");
    run_op(pk32(32'h3F801000, 32'hBF801000, 32'h3F803000, 32'h3F801001), pk32(ONE, ONE, ONE, ONE),
           2'd1, 0, 0, pk16(16'h3C01, 16'hBC00, 16'h3C02, 16'h3C01, H1, H1, H1, H1), 4'b0001, "R4 up");
    run_op(pk32(32'h3F801000, 32'hBF801000, 32'h3F803000, 32'h3F801001), pk32(ONE, ONE, ONE, ONE),
           2'd2, 0, 0, pk16(16'h3C00, 16'hBC01, 16'h3C01, 16'h3C00, H1, H1, H1, H1), 4'b0001, "R4 down");
    run_op(pk32(32'h3F801000, 32'hBF801000, 32'h3F803000, 32'h3F801001), pk32(ONE, ONE, ONE, ONE),
           2'd3, 0, 0, pk16(16'h3C00, 16'hBC00, 16'h3C01, 16'h3C00, H1, H1, H1, H1), 4'b0001, "R4 zero");

    // R5: overflow per direction
    run_op(pk32(32'h477FF000, 32'h501502F9, 32'hD01502F9, 32'h477FE000), pk32(ONE, ONE, ONE, ONE),
           2'd0, 0, 0, pk16(16'h7C00, 16'h7C00, 16'hFC00, 16'h7BFF, H1, H1, H1, H1), 4'b0101, "R5 nearest");
    run_op(pk32(32'h477FF000, 32'h501502F9, 32'hD01502F9, 32'h477FE000), pk32(ONE, ONE, ONE, ONE),
           2'd3, 0, 0, pk16(16'h7BFF, 16'h7BFF, 16'hFBFF, 16'h7BFF, H1, H1, H1, H1), 4'b0101, "R5 zero");
    run_op(pk32(32'h477FF000, 32'h501502F9, 32'hD01502F9, 32'h477FE000), pk32(ONE, ONE, ONE, ONE),
           2'd1, 0, 0, pk16(16'h7C00, 16'h7C00, 16'hFBFF, 16'h7BFF, H1, H1, H1, H1), 4'b0101, "R5 up");
    run_op(pk32(32'h477FF000, 32'h501502F9, 32'hD01502F9, 32'h477FE000), pk32(ONE, ONE, ONE, ONE),
           2'd2, 0, 0, pk16(16'h7BFF, 16'h7BFF, 16'hFC00, 16'h7BFF, H1, H1, H1, H1), 4'b0101, "R5 down");
    run_op(pk32(32'h477FF000, ONE, ONE, ONE), pk32(ONE, ONE, ONE, ONE),
           2'd3, 0, 0, pk16(16'h7BFF, H1, H1, H1, H1, H1, H1, H1), 4'b0001, "R5 no overflow when truncated");

    // R6: subnormal results
    run_op(pk32(32'h33800000, 32'h33000000, 32'h33C00000, 32'h00000001),
           pk32(32'h38800000, 32'hB3800000, ONE, ONE), 2'd0, 0, 0,
           pk16(16'h0001, 16'h0000, 16'h0002, 16'h0000, 16'h0400, 16'h8001, H1, H1), 4'b0011, "R6 nearest");
    run_op(pk32(32'h33800000, 32'hB3800000, 32'h38800000, ONE), pk32(ONE, ONE, ONE, ONE), 2'd0, 0, 0,
           pk16(16'h0001, 16'h8001, 16'h0400, H1, H1, H1, H1, H1), 4'b0000, "R6 exact subnormal");
    run_op(pk32(32'h33000000, 32'h00000001, 32'hB3000000, ONE), pk32(ONE, ONE, ONE, ONE), 2'd1, 0, 0,
           pk16(16'h0001, 16'h0001, 16'h8000, H1, H1, H1, H1, H1), 4'b0011, "R6 up");

    // R7: flush to zero
    run_op(pk32(32'h33800000, 32'hB3800000, 32'h00000001, ONE), pk32(32'h38800000, ONE, ONE, ONE), 2'd0, 0, 1,
           pk16(16'h0000, 16'h8000, 16'h0000, H1, 16'h0400, H1, H1, H1), 4'b0010, "R7 flush");
    run_op(pk32(32'h80000001, 32'h00000001, ONE, ONE), pk32(ONE, ONE, ONE, ONE), 2'd1, 0, 1,
           pk16(16'h8000, 16'h0000, H1, H1, H1, H1, H1, H1), 4'b0000, "R7 denormal input");

    // R8 R9 R10: special values
    run_op(pk32(32'h7FC00000, 32'h7F800001, 32'h7FA00000, 32'hFFC02000), pk32(ONE, ONE, ONE, ONE), 2'd0, 0, 0,
           pk16(16'h7E00, 16'h7E00, 16'h7F00, 16'hFE01, H1, H1, H1, H1), 4'b1000, "R8 payload");
    run_op(pk32(32'h7FC00000, 32'hFFC02000, 32'h7F800000, 32'hFF800000),
           pk32(32'h80000000, 32'h00000000, ONE, ONE), 2'd0, 0, 0,
           pk16(16'h7E00, 16'hFE01, 16'h7C00, 16'hFC00, 16'h8000, 16'h0000, H1, H1), 4'b0000, "R8 R10 quiet inf zero");
    run_op(pk32(32'h7FC00000, 32'h7F800001, 32'h7FA00000, 32'hFFC02000), pk32(ONE, ONE, ONE, ONE), 2'd0, 1, 0,
           pk16(16'h7E00, 16'h7E00, 16'h7E00, 16'h7E00, H1, H1, H1, H1), 4'b1000, "R9 default NaN");

    // R11: flags from several lanes in both halves merge
    run_op(pk32(32'h501502F9, 32'h3F801000, ONE, ONE), pk32(32'h7F800001, 32'h33000000, ONE, ONE), 2'd0, 0, 0,
           pk16(16'h7C00, H1, H1, H1, 16'h7E00, 16'h0000, H1, H1), 4'b1111, "R11 merged");

    // R2: back-pressure
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    @(posedge clk); #1 out_ready = 1'b0;
    @(negedge clk);
    run_op(pk32(ONE, 32'h40000000, 32'hBFC00000, 32'h3F000000),
           pk32(32'h477FE000, 32'h38800000, 32'h40400000, 32'hC0800000), 2'd0, 0, 0,
           pk16(H1, 16'h4000, 16'hBE00, 16'h3800, 16'h7BFF, 16'h0400, 16'h4200, 16'hC400),
           4'b0000, "R2 stalled first");
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b1, "R2 valid held in stall", {127'b0, out_valid}, 128'd1);
    check(in_ready == 1'b0, "R2 not ready in stall", {127'b0, in_ready}, '0);
    check(out_data == pk16(H1, 16'h4000, 16'hBE00, 16'h3800, 16'h7BFF, 16'h0400, 16'h4200, 16'hC400),
          "R2 data held in stall", out_data,
          pk16(H1, 16'h4000, 16'hBE00, 16'h3800, 16'h7BFF, 16'h0400, 16'h4200, 16'hC400));
    fork
      run_op(pk32(32'hC0800000, ONE, ONE, ONE), pk32(ONE, ONE, ONE, 32'h40000000), 2'd0, 0, 0,
             pk16(16'hC400, H1, H1, H1, H1, H1, H1, 16'h4000), 4'b0000, "R2 R1 waited second");
      begin
        repeat (2) @(posedge clk);
        #1 out_ready = 1'b1;
      end
    join
    in_valid = 1'b0;

    for (int k = 0; k < 20 && exp_d_q.size() != 0; k++) @(negedge clk);
    check(exp_d_q.size() == 0, "R2 all results delivered", exp_d_q.size(), '0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule